// File: doc/BRIEF.md
# I2C Packet Transfer Sequencer

This block turns a stream of 32-bit words into I2C bus transactions. It pops a three-word header from a transmit word queue. The header carries the controller tag, the byte count, the target address, the direction and the packet options. For a write, the payload words follow the header. The sequencer breaks each word into bytes and issues byte-level commands (start, address byte, write byte, read byte, repeated start, stop) to an external bit engine. It handles one command at a time.

For a read packet, the bytes returned by the engine are gathered four to a word and pushed into a receive word queue. Three conditions are reported as single-cycle pulses to an interrupt block: a missing acknowledge, a lost arbitration and a completed packet. The high-speed and start-byte options are decoded and presented on ports for the bit engine. The same holds for the packet tag. The sequencer does not act on them.

Top module: `pkt_i2c_seq`

## Requirements
- R1: Header word 0 is accepted only when its bit 4 (protocol flag) is 1. A word with bit 4 clear is popped and dropped, no bus command follows, and the sequencer stays idle.
- R2: Header word 1 bits [LEN_W-1:0] give the byte count minus one. Header word 2 carries these flags: bit 16 repeat-start ending, bit 17 completion event enable, bit 18 ten-bit address, bit 19 read, bit 20 start-byte request, bit 21 continue after missing acknowledge, bit 22 high speed. `hs_mode`, `start_byte` and `pkt_id` (word 0 bits [23:16]) show the last accepted header.
- R3: A seven-bit address is taken from word 2 bits [7:1] and sent as the byte {addr[6:0], rd}. A ten-bit address is taken from bits [9:0] and sent as {5'b11110, addr[9:8], rd} followed by addr[7:0].
- R4: Write payload is little-endian: byte k of a packet is bits [8*(k%4)+7:8*(k%4)] of payload word k/4. The unused bytes of a partial final word are never sent. Every payload word is popped.
- R5: A read packet issues one read command per byte. `cmd_rd_nack` is 1 only on the last byte. Received bytes are packed little-endian and a word is pushed when it is full or holds the last byte. Unused bytes of a partial final word are zero.
- R6: A packet ends with a stop command (op 4), or with a repeated-start command (op 1) when the repeat-start flag is set. The packet after a repeated-start ending issues no start command (op 0).
- R7: `ev_pkt_done` pulses once, in the cycle after the ending command completes, and only when the completion event enable flag is set and the packet was not aborted.
- R8: A missing acknowledge on an address or write byte pulses `ev_nack` before any stop command is issued. Without the continue flag, the packet then issues a stop, gives no completion event, and the remaining payload words are popped and dropped.
- R9: With the continue flag set, a missing acknowledge still pulses `ev_nack`, but the packet runs to its normal ending and completion event.
- R10: Lost arbitration on any command pulses `ev_arb_lost`. No further bus command is issued for that packet, and its remaining payload words are popped and dropped.
- R11: Command handshake: `cmd_valid` stays high with `cmd_op` and `cmd_wbyte` stable until `cmd_done`, and only one command is outstanding at a time. Op codes: 0 start, 1 repeated start, 2 write byte, 3 read byte, 4 stop.
- R12: After reset, `busy`, `cmd_valid`, `tx_pop`, `rx_push` and all event pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_data | input | 32 | Head word of transmit queue |
| tx_pop | output | 1 | Consume head word this cycle |
| rx_push | output | 1 | Push received word |
| rx_data | output | 32 | Received word |
| cmd_valid | output | 1 | Command to bit engine pending |
| cmd_op | output | 3 | Command code |
| cmd_wbyte | output | 8 | Byte to send for write command |
| cmd_rd_nack | output | 1 | Master answers read byte with not-acknowledge |
| cmd_done | input | 1 | Bit engine finished pending command |
| rsp_nack | input | 1 | Target did not acknowledge (with cmd_done) |
| rsp_arb_lost | input | 1 | Arbitration lost (with cmd_done) |
| rsp_rbyte | input | 8 | Byte read from bus (with cmd_done) |
| ev_nack | output | 1 | Missing acknowledge event pulse |
| ev_arb_lost | output | 1 | Arbitration lost event pulse |
| ev_pkt_done | output | 1 | Packet complete event pulse |
| busy | output | 1 | A packet is in progress |
| hs_mode | output | 1 | High-speed flag of current header |
| start_byte | output | 1 | Start-byte flag of current header |
| pkt_id | output | 8 | Packet tag of current header |

## Verification
A wrong byte counter or lane index shows up at the command port within one command. It appears as a misplaced byte, a read without the final not-acknowledge, or a stop that comes one byte early or late. A stale abort or bus-held flag changes the start or ending command of the same packet or the next one. A word-pop count that drifts leaves the transmit queue misaligned, and the next header then decodes as junk in the following packet. The bench compares the full command trace, the event counts, the received words and the queue drain after every packet, so each of these faults is caught within the packet where it occurs or the one after.

// File: rtl/pi2c_pkg.sv
package pi2c_pkg;
    localparam int WORD_W      = 32;
    localparam int PROTO_BIT   = 4;
    localparam int TAG_LSB     = 16;
    localparam int TAG_W       = 8;
    localparam int F_RS        = 16;
    localparam int F_IE        = 17;
    localparam int F_TEN       = 18;
    localparam int F_RD        = 19;
    localparam int F_SB        = 20;
    localparam int F_CONT      = 21;
    localparam int F_HS        = 22;

    typedef enum logic [2:0] {
        OP_START  = 3'd0,
        OP_RSTART = 3'd1,
        OP_WRITE  = 3'd2,
        OP_READ   = 3'd3,
        OP_STOP   = 3'd4
    } op_e;

    typedef struct packed {
        logic rs;
        logic ie;
        logic ten;
        logic rd;
        logic sb;
        logic cont;
        logic hs;
    } flags_t;

    typedef enum logic [3:0] {
        S_IDLE, S_LEN, S_ADRHDR, S_START, S_ADDR1, S_ADDR2, S_XFER, S_END, S_DRAIN
    } seq_state_e;
endpackage

// File: rtl/pi2c_hdr_dec.sv
module pi2c_hdr_dec
    import pi2c_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              proto_ok,
    output logic [TAG_W-1:0]  tag,
    output flags_t            flags,
    output logic [9:0]        taddr
);
    always_comb begin
        proto_ok   = word[PROTO_BIT];
        tag        = word[TAG_LSB +: TAG_W];
        flags.rs   = word[F_RS];
        flags.ie   = word[F_IE];
        flags.ten  = word[F_TEN];
        flags.rd   = word[F_RD];
        flags.sb   = word[F_SB];
        flags.cont = word[F_CONT];
        flags.hs   = word[F_HS];
        taddr      = word[9:0];
    end
endmodule

// File: rtl/pi2c_addr_gen.sv
module pi2c_addr_gen (
    input  logic       ten,
    input  logic       rd,
    input  logic [9:0] taddr,
    output logic [7:0] first_b,
    output logic [7:0] second_b
);
    always_comb begin
        if (ten) begin
            first_b  = {5'b11110, taddr[9:8], rd};
            second_b = taddr[7:0];
        end else begin
            first_b  = {taddr[7:1], rd};
            second_b = 8'h00;
        end
    end
endmodule

// File: rtl/pi2c_rx_pack.sv
module pi2c_rx_pack #(
    parameter int BPW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             byte_vld,
    input  logic [7:0]       byte_in,
    input  logic             last,
    output logic             push,
    output logic [8*BPW-1:0] word
);
    localparam int LANE_W = $clog2(BPW);
    localparam int WW     = 8 * BPW;

    typedef struct packed {
        logic [WW-1:0]     acc;
        logic [LANE_W-1:0] lane;
        logic              push;
        logic [WW-1:0]     word;
    } pk_t;

    pk_t q, d;

    always_comb begin
        logic [WW-1:0] tmp;
        d      = q;
        d.push = 1'b0;
        tmp    = q.acc;
        if (clr) begin
            d.acc  = '0;
            d.lane = '0;
        end else if (byte_vld) begin
            tmp[{q.lane, 3'b000} +: 8] = byte_in;
            if (last || q.lane == LANE_W'(BPW - 1)) begin
                d.push = 1'b1;
                d.word = tmp;
                d.acc  = '0;
                d.lane = '0;
            end else begin
                d.acc  = tmp;
                d.lane = q.lane + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign push = q.push;
    assign word = q.word;

    // R5
    rx_lane_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.push |-> (q.lane == '0) && (q.acc == '0));
endmodule

// File: rtl/pkt_i2c_seq.sv
module pkt_i2c_seq
    import pi2c_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_valid,
    input  logic [31:0] tx_data,
    output logic        tx_pop,
    output logic        rx_push,
    output logic [31:0] rx_data,
    output logic        cmd_valid,
    output logic [2:0]  cmd_op,
    output logic [7:0]  cmd_wbyte,
    output logic        cmd_rd_nack,
    input  logic        cmd_done,
    input  logic        rsp_nack,
    input  logic        rsp_arb_lost,
    input  logic [7:0]  rsp_rbyte,
    output logic        ev_nack,
    output logic        ev_arb_lost,
    output logic        ev_pkt_done,
    output logic        busy,
    output logic        hs_mode,
    output logic        start_byte,
    output logic [7:0]  pkt_id
);
    localparam int CNT_W = LEN_W + 1;

    typedef struct packed {
        seq_state_e        st;
        flags_t            fl;
        logic [9:0]        taddr;
        logic [TAG_W-1:0]  tag;
        logic [LEN_W-1:0]  len;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  wpop;
        logic [31:0]       wbuf;
        logic              cmdv;
        op_e               op;
        logic [7:0]        wbyte;
        logic              rdnack;
        logic              abort;
        logic              held;
        logic              ev_nack;
        logic              ev_arb;
        logic              ev_done;
    } seq_t;

    seq_t q, d;

    logic             dec_proto;
    logic [TAG_W-1:0] dec_tag;
    flags_t           dec_fl;
    logic [9:0]       dec_addr;
    logic [7:0]       adr_b0, adr_b1;
    logic             rx_vld, rx_last, rx_clr;

    pi2c_hdr_dec u_dec (
        .word     (tx_data),
        .proto_ok (dec_proto),
        .tag      (dec_tag),
        .flags    (dec_fl),
        .taddr    (dec_addr)
    );

    pi2c_addr_gen u_adr (
        .ten      (q.fl.ten),
        .rd       (q.fl.rd),
        .taddr    (q.taddr),
        .first_b  (adr_b0),
        .second_b (adr_b1)
    );

    pi2c_rx_pack #(.BPW(4)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_clr),
        .byte_vld (rx_vld),
        .byte_in  (rsp_rbyte),
        .last     (rx_last),
        .push     (rx_push),
        .word     (rx_data)
    );

    always_comb begin
        logic             done;
        logic             wr_rsp;
        seq_state_e       wr_nxt;
        logic             last_b;
        logic [CNT_W-1:0] words_total;

        d          = q;
        d.ev_nack  = 1'b0;
        d.ev_arb   = 1'b0;
        d.ev_done  = 1'b0;
        tx_pop     = 1'b0;
        rx_vld     = 1'b0;
        rx_last    = 1'b0;
        rx_clr     = 1'b0;
        wr_rsp     = 1'b0;
        wr_nxt     = S_IDLE;
        done       = q.cmdv && cmd_done;
        last_b     = (q.cnt == CNT_W'(q.len));
        words_total = CNT_W'(q.len >> 2) + 1'b1;

        case (q.st)
            S_IDLE: begin
                if (tx_valid) begin
                    tx_pop = 1'b1;
                    if (dec_proto) begin
                        d.tag = dec_tag;
                        d.st  = S_LEN;
                    end
                end
            end
            S_LEN: begin
                if (tx_valid) begin
                    tx_pop = 1'b1;
                    d.len  = tx_data[LEN_W-1:0];
                    d.st   = S_ADRHDR;
                end
            end
            S_ADRHDR: begin
                if (tx_valid) begin
                    tx_pop  = 1'b1;
                    rx_clr  = 1'b1;
                    d.fl    = dec_fl;
                    d.taddr = dec_addr;
                    d.cnt   = '0;
                    d.wpop  = '0;
                    d.abort = 1'b0;
                    d.st    = S_START;
                end
            end
            S_START: begin
                if (q.held) begin
                    d.held = 1'b0;
                    d.st   = S_ADDR1;
                end else if (!q.cmdv) begin
                    d.cmdv   = 1'b1;
                    d.op     = OP_START;
                    d.rdnack = 1'b0;
                end else if (done) begin
                    d.cmdv = 1'b0;
                    if (rsp_arb_lost) begin
                        d.ev_arb = 1'b1;
                        d.abort  = 1'b1;
                        d.st     = S_DRAIN;
                    end else begin
                        d.st = S_ADDR1;
                    end
                end
            end
            S_ADDR1, S_ADDR2: begin
                if (!q.cmdv) begin
                    d.cmdv   = 1'b1;
                    d.op     = OP_WRITE;
                    d.rdnack = 1'b0;
                    d.wbyte  = (q.st == S_ADDR1) ? adr_b0 : adr_b1;
                end else if (done) begin
                    wr_rsp = 1'b1;
                    wr_nxt = (q.st == S_ADDR1 && q.fl.ten) ? S_ADDR2 : S_XFER;
                end
            end
            S_XFER: begin
                if (!q.cmdv) begin
                    if (q.fl.rd) begin
                        d.cmdv   = 1'b1;
                        d.op     = OP_READ;
                        d.rdnack = last_b;
                    end else if (q.cnt[1:0] == 2'd0) begin
                        if (tx_valid) begin
                            tx_pop   = 1'b1;
                            d.wbuf   = tx_data;
                            d.wbyte  = tx_data[7:0];
                            d.wpop   = q.wpop + 1'b1;
                            d.cmdv   = 1'b1;
                            d.op     = OP_WRITE;
                            d.rdnack = 1'b0;
                        end
                    end else begin
                        d.wbyte  = q.wbuf[{q.cnt[1:0], 3'b000} +: 8];
                        d.cmdv   = 1'b1;
                        d.op     = OP_WRITE;
                        d.rdnack = 1'b0;
                    end
                end else if (done) begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.fl.rd) begin
                        d.cmdv = 1'b0;
                        if (rsp_arb_lost) begin
                            d.ev_arb = 1'b1;
                            d.abort  = 1'b1;
                            rx_clr   = 1'b1;
                            d.st     = S_DRAIN;
                        end else begin
                            rx_vld  = 1'b1;
                            rx_last = last_b;
                            if (last_b) d.st = S_END;
                        end
                    end else begin
                        wr_rsp = 1'b1;
                        wr_nxt = last_b ? S_END : S_XFER;
                    end
                end
            end
            S_END: begin
                if (!q.cmdv) begin
                    d.cmdv   = 1'b1;
                    d.op     = (!q.abort && q.fl.rs) ? OP_RSTART : OP_STOP;
                    d.rdnack = 1'b0;
                end else if (done) begin
                    d.cmdv = 1'b0;
                    if (rsp_arb_lost) begin
                        d.ev_arb = 1'b1;
                        d.abort  = 1'b1;
                        d.st     = S_DRAIN;
                    end else begin
                        d.ev_done = !q.abort && q.fl.ie;
                        d.held    = !q.abort && q.fl.rs;
                        d.st      = q.abort ? S_DRAIN : S_IDLE;
                    end
                end
            end
            S_DRAIN: begin
                if (q.fl.rd || q.wpop >= words_total) begin
                    d.st = S_IDLE;
                end else if (tx_valid) begin
                    tx_pop = 1'b1;
                    d.wpop = q.wpop + 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (wr_rsp) begin
            d.cmdv = 1'b0;
            if (rsp_arb_lost) begin
                d.ev_arb = 1'b1;
                d.abort  = 1'b1;
                d.st     = S_DRAIN;
            end else if (rsp_nack) begin
                d.ev_nack = 1'b1;
                if (q.fl.cont) begin
                    d.st = wr_nxt;
                end else begin
                    d.abort = 1'b1;
                    d.st    = S_END;
                end
            end else begin
                d.st = wr_nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
            q.op <= OP_START;
        end else begin
            q <= d;
        end
    end

    assign cmd_valid   = q.cmdv;
    assign cmd_op      = q.op;
    assign cmd_wbyte   = q.wbyte;
    assign cmd_rd_nack = q.rdnack;
    assign ev_nack     = q.ev_nack;
    assign ev_arb_lost = q.ev_arb;
    assign ev_pkt_done = q.ev_done;
    assign busy        = (q.st != S_IDLE);
    assign hs_mode     = q.fl.hs;
    assign start_byte  = q.fl.sb;
    assign pkt_id      = q.tag;

    // R11
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_wbyte)));
    // R11
    done_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> cmd_valid);
    // R8
    nack_before_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack |-> ($past(cmd_done) && $past(rsp_nack) && !cmd_valid));
    // R7
    done_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pkt_done |-> ($past(cmd_done) &&
                        ($past(cmd_op) == 3'(OP_STOP) || $past(cmd_op) == 3'(OP_RSTART))));
    // R10
    arb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_arb_lost |=> !cmd_valid);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE) |-> !cmd_valid);
    // R7
    event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_nack, ev_arb_lost, ev_pkt_done}));
endmodule

// File: tb/pkt_i2c_seq_test.sv
module pkt_i2c_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_valid;
    logic [31:0] tx_data;
    logic        tx_pop;
    logic        rx_push;
    logic [31:0] rx_data;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [7:0]  cmd_wbyte;
    logic        cmd_rd_nack;
    logic        cmd_done = 1'b0;
    logic        rsp_nack = 1'b0;
    logic        rsp_arb_lost = 1'b0;
    logic [7:0]  rsp_rbyte = 8'h00;
    logic        ev_nack, ev_arb_lost, ev_pkt_done, busy, hs_mode, start_byte;
    logic [7:0]  pkt_id;

    always #2 clk = ~clk;

    pkt_i2c_seq uut (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wbyte(cmd_wbyte), .cmd_rd_nack(cmd_rd_nack), .cmd_done(cmd_done),
        .rsp_nack(rsp_nack), .rsp_arb_lost(rsp_arb_lost), .rsp_rbyte(rsp_rbyte),
        .ev_nack(ev_nack), .ev_arb_lost(ev_arb_lost), .ev_pkt_done(ev_pkt_done),
        .busy(busy), .hs_mode(hs_mode), .start_byte(start_byte), .pkt_id(pkt_id)
    );

    // transmit word queue
    logic [31:0] txq [0:1023];
    int tx_wr = 0;
    int tx_rd = 0;
    assign tx_valid = (tx_rd < tx_wr);
    assign tx_data  = txq[tx_rd[9:0]];
    always @(posedge clk) if (tx_pop) tx_rd <= tx_rd + 1;

    // target / bit engine model
    int log_v [0:2047];
    int log_n = 0;
    int wr_n = 0;
    int rd_n = 0;
    int nack_at = -1;
    int arb_at = -1;
    int dly = 0;

    function automatic logic [7:0] rgen(int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    function automatic int enc(int op, int rdn, int b);
        return op * 512 + ((op == 3) ? rdn * 256 : 0) + ((op == 2) ? b : 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            cmd_done <= 1'b0;
        end else if (cmd_done) begin
            cmd_done <= 1'b0;
        end else if (cmd_valid) begin
            if (dly > 0) dly <= dly - 1;
            else begin
                cmd_done     <= 1'b1;
                log_v[log_n] <= enc(int'(cmd_op), int'(cmd_rd_nack), int'(cmd_wbyte));
                log_n        <= log_n + 1;
                rsp_nack     <= (cmd_op == 3'd2) && (wr_n == nack_at);
                rsp_arb_lost <= (log_n == arb_at);
                if (cmd_op == 3'd2) wr_n <= wr_n + 1;
                if (cmd_op == 3'd3) begin
                    rsp_rbyte <= rgen(rd_n);
                    rd_n      <= rd_n + 1;
                end
                dly <= int'($urandom % 3);
            end
        end
    end

    // event and receive monitors
    int n_nack = 0, n_arb = 0, n_done = 0, rx_n = 0, hs_err = 0;
    logic [31:0] rx_v [0:511];
    always @(posedge clk) begin
        if (ev_nack) n_nack <= n_nack + 1;
        if (ev_arb_lost) n_arb <= n_arb + 1;
        if (ev_pkt_done) n_done <= n_done + 1;
        if (rx_push) begin
            rx_v[rx_n] <= rx_data;
            rx_n <= rx_n + 1;
        end
    end

    logic pv = 1'b0, pdn = 1'b0;
    logic [2:0] pop_s = 3'd0;
    logic [7:0] pby = 8'd0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pv && !pdn && (!cmd_valid || cmd_op != pop_s || cmd_wbyte != pby)) hs_err = hs_err + 1;
            pv = cmd_valid; pdn = cmd_done; pop_s = cmd_op; pby = cmd_wbyte;
        end
    end

    int n_tests = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // expected-model state
    int  exp_log [0:63];
    int  e_n, ew, ec;
    bit  e_arb;
    bit  exp_held = 1'b0;
    int  nack_rel_g, arb_rel_g;

    task automatic exp_cmd(input int code, input bit is_wr, output bit nk);
        nk = 1'b0;
        if (e_arb) return;
        exp_log[e_n] = code;
        e_n++;
        nk = is_wr && (ew == nack_rel_g);
        if (is_wr) ew++;
        if (ec == arb_rel_g) e_arb = 1'b1;
        ec++;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            if (tx_rd == tx_wr && !busy && !cmd_valid && !cmd_done) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic run_pkt(input bit rd, input bit ten, input bit rs, input bit ie,
                           input bit cont, input bit hs, input bit sb, input int addr,
                           input int len, input int nack_rel, input int arb_rel, input string tag);
        int log0, wr0, rd0, nk0, ab0, dn0, rx0;
        int e_nack, words;
        bit abort, nk;
        logic [7:0] base, pid;
        logic [7:0] pl [0:15];
        logic [31:0] w2, ex_rx [0:3];
        logic [7:0] b;
        bit ok;

        log0 = log_n; wr0 = wr_n; rd0 = rd_n; nk0 = n_nack; ab0 = n_arb; dn0 = n_done; rx0 = rx_n;
        nack_at = (nack_rel < 0) ? -1 : wr0 + nack_rel;
        arb_at  = (arb_rel < 0) ? -1 : log0 + arb_rel;
        base = 8'($urandom);
        pid  = 8'($urandom);
        for (int i = 0; i < 16; i++) pl[i] = base + 8'(i * 29);

        w2 = (32'(rs) << 16) | (32'(ie) << 17) | (32'(ten) << 18) | (32'(rd) << 19) |
             (32'(sb) << 20) | (32'(cont) << 21) | (32'(hs) << 22) |
             (ten ? 32'(addr & 1023) : 32'((addr & 127) << 1));
        txq[tx_wr[9:0]]     = (32'(pid) << 16) | (32'd3 << 12) | 32'h10;
        txq[tx_wr[9:0] + 1] = 32'(len - 1);
        txq[tx_wr[9:0] + 2] = w2;
        words = 3;
        if (!rd) begin
            for (int j = 0; j < (len + 3) / 4; j++) begin
                logic [31:0] w;
                for (int k = 0; k < 4; k++) begin
                    b = (4 * j + k < len) ? pl[4 * j + k] : 8'hEE;
                    w[8 * k +: 8] = b;
                end
                txq[tx_wr[9:0] + 10'(words)] = w;
                words++;
            end
        end
        @(negedge clk);
        tx_wr = tx_wr + words;
        wait_idle();

        // expected sequence
        e_n = 0; ew = 0; ec = 0; e_arb = 1'b0; e_nack = 0; abort = 1'b0;
        nack_rel_g = nack_rel; arb_rel_g = arb_rel;
        for (int i = 0; i < 4; i++) ex_rx[i] = 32'h0;
        if (!exp_held) exp_cmd(enc(0, 0, 0), 1'b0, nk);
        if (ten) b = {5'b11110, 2'(addr >> 8), rd};
        else     b = {7'(addr), rd};
        exp_cmd(enc(2, 0, int'(b)), 1'b1, nk);
        if (nk && !e_arb) begin e_nack++; if (!cont) abort = 1'b1; end
        if (ten && !abort && !e_arb) begin
            exp_cmd(enc(2, 0, addr & 255), 1'b1, nk);
            if (nk && !e_arb) begin e_nack++; if (!cont) abort = 1'b1; end
        end
        for (int i = 0; i < len; i++) begin
            if (abort || e_arb) break;
            if (rd) begin
                exp_cmd(enc(3, (i == len - 1) ? 1 : 0, 0), 1'b0, nk);
                ex_rx[i / 4][8 * (i % 4) +: 8] = rgen(rd0 + i);
            end else begin
                exp_cmd(enc(2, 0, int'(pl[i])), 1'b1, nk);
                if (nk && !e_arb) begin e_nack++; if (!cont) abort = 1'b1; end
            end
        end
        if (!e_arb) exp_cmd(enc((abort || !rs) ? 4 : 1, 0, 0), 1'b0, nk);

        // compare
        check(log_n - log0 == e_n, tag, "command count", log_n - log0, e_n);
        ok = 1'b1;
        for (int i = 0; i < e_n && i < log_n - log0; i++) begin
            if (log_v[log0 + i] != exp_log[i]) begin
                ok = 1'b0;
                check(1'b0, tag, $sformatf("command %0d", i), log_v[log0 + i], exp_log[i]);
                break;
            end
        end
        if (ok) check(1'b1, tag, "command sequence", 0, 0);
        check(n_nack - nk0 == e_nack, "R8", "nack events", n_nack - nk0, e_nack);
        check(n_done - dn0 == ((!e_arb && !abort && ie) ? 1 : 0), "R7", "done events",
              n_done - dn0, (!e_arb && !abort && ie) ? 1 : 0);
        check(n_arb - ab0 == (e_arb ? 1 : 0), "R10", "arb events", n_arb - ab0, e_arb ? 1 : 0);
        begin
            int exp_words;
            exp_words = (rd && !abort && !e_arb) ? (len + 3) / 4 : 0;
            check(rx_n - rx0 == exp_words, "R5", "rx word count", rx_n - rx0, exp_words);
            for (int i = 0; i < exp_words && i < rx_n - rx0; i++)
                check(rx_v[rx0 + i] == ex_rx[i], "R5", $sformatf("rx word %0d", i),
                      int'(rx_v[rx0 + i]), int'(ex_rx[i]));
        end
        check(tx_rd == tx_wr, "R4", "tx queue drained", tx_rd, tx_wr);
        check(hs_mode == hs && start_byte == sb && pkt_id == pid, "R2", "reported header fields",
              int'({hs_mode, start_byte, pkt_id}), int'({hs, sb, pid}));
        exp_held = !e_arb && !abort && rs;
    endtask

    initial begin
        int lc, rc;
        void'($urandom(32'h5eed_1c2d));
        repeat (3) @(negedge clk);
        // R12 reset state
        check(!busy && !cmd_valid && !tx_pop && !rx_push && !ev_nack && !ev_arb_lost && !ev_pkt_done,
              "R12", "reset outputs", int'({busy, cmd_valid, tx_pop, rx_push}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !cmd_valid, "R12", "idle after reset", int'({busy, cmd_valid}), 0);

        // directed cases
        run_pkt(0, 0, 0, 1, 0, 0, 0, 7'h52, 1, -1, -1, "R4");   // partial single byte write
        run_pkt(0, 0, 0, 1, 0, 1, 1, 7'h11, 4, -1, -1, "R4");   // exact word write
        run_pkt(1, 1, 0, 1, 0, 0, 0, 10'h2A5, 6, -1, -1, "R3"); // ten-bit read, partial word
        run_pkt(1, 0, 0, 1, 0, 0, 0, 7'h33, 9, -1, -1, "R5");
        run_pkt(0, 0, 1, 1, 0, 0, 0, 7'h40, 3, -1, -1, "R6");   // repeat-start ending
        run_pkt(1, 0, 0, 1, 0, 0, 0, 7'h40, 2, -1, -1, "R6");   // no start after it
        run_pkt(0, 0, 0, 1, 0, 0, 0, 7'h21, 10, 3, -1, "R8");   // nack on data, abort and drain
        run_pkt(0, 1, 0, 1, 1, 0, 0, 10'h155, 5, 1, -1, "R9");  // nack continue
        run_pkt(0, 0, 0, 0, 0, 0, 0, 7'h05, 2, -1, -1, "R7");   // no completion event
        run_pkt(0, 0, 0, 1, 0, 0, 0, 7'h6C, 11, -1, 4, "R10");  // arbitration lost mid write
        run_pkt(0, 0, 0, 1, 0, 0, 0, 7'h0F, 1, 0, -1, "R8");    // nack on address

        // R1 protocol flag clear
        lc = log_n;
        txq[tx_wr[9:0]] = 32'h0003_3000;
        @(negedge clk);
        tx_wr = tx_wr + 1;
        wait_idle();
        check(log_n == lc, "R1", "junk header issues no command", log_n - lc, 0);
        check(tx_rd == tx_wr && !busy, "R1", "junk header dropped", tx_wr - tx_rd, 0);
        run_pkt(0, 0, 0, 1, 0, 0, 0, 7'h3C, 2, -1, -1, "R1");

        // random packets
        for (int p = 0; p < 24; p++) begin
            bit rd, ten, rs, ie, cont, hs, sb;
            int addr, len, wc, nr;
            rd = 1'($urandom); ten = ($urandom % 4) == 0; rs = ($urandom % 3) == 0;
            ie = ($urandom % 4) != 0; cont = 1'($urandom); hs = 1'($urandom); sb = 1'($urandom);
            addr = ten ? int'($urandom % 1024) : int'($urandom % 128);
            len = 1 + int'($urandom % 11);
            wc = (ten ? 2 : 1) + (rd ? 0 : len);
            nr = (($urandom % 3) == 0) ? int'($urandom % wc) : -1;
            run_pkt(rd, ten, rs, ie, cont, hs, sb, addr, len, nr, -1, "R11");
        end

        rc = hs_err;
        check(rc == 0, "R11", "handshake stability violations", rc, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
        $finish;
    end
endmodule